// File: doc/BRIEF.md
# Holdover and Monotonic Time Restore Controller

This block owns a free-running local time counter and decides, cycle by cycle, how far it advances. It has three modes: disciplined (a servo is feeding it offset measurements), holdover (the reference has gone away and the counter runs on its nominal rate alone), and restoring (the reference is back and the accumulated error is being worked off). Every mode change produces a one-cycle event marker stamped with the local time, so a log can show exactly when time quality changed.

The central rule is that local time never moves backward. A negative correction is never subtracted. It is held as a pending error and worked off by advancing less than the nominal amount per cycle, within a clamp and never by less than one unit. Positive errors are worked off the same way while restoring. While disciplined, a positive error can be applied as a single forward step, selected by a parameter. An external time load, such as a wall-clock value after boot, is accepted only if it does not point into the past. A backward load is refused, counted, and latched in a sticky flag.

The block also measures how long each restore took, from leaving holdover to relocking, and flags when that exceeds a limit. Reset counts as a reboot and leaves the block in holdover.

Top module: `hold_restore_ctrl`

## Requirements
- R1: During and right after reset, time_now is 0, the mode code is holdover (1), holdover_flag is 1, evt_valid is 0, viol_count is 0, viol_sticky is 0 and restore_time is 0.
- R2: Outside an accepted load, time_now increases by at least 1 on every clock cycle, so it never repeats or decreases.
- R3: In the disciplined mode (code 0) with STEP_FWD set, a servo update with a positive offset adds NOM_INC plus the full offset on the next edge. A negative offset is stored and first affects the increment one edge later.
- R4: A stored error changes the per-cycle increment from NOM_INC by at most MAX_SLEW up and at most MAX_SLEW down, with a floor of 1. The increments sum to NOM_INC per cycle plus the full offset once the error is used up. With defaults NOM_INC=4 and MAX_SLEW=6, the increment lies between 1 and 10.
- R5: When link_up or gm_present is low in the disciplined or restoring mode, the next edge enters holdover (code 1), raises holdover_flag, and pulses evt_valid with evt_code 1.
- R6: In holdover, servo updates are ignored and time_now advances by exactly NOM_INC per cycle.
- R7: When both link_up and gm_present are high in holdover, the next edge enters restoring (code 2) with evt_code 2 and holdover_flag low. In restoring, positive offsets are slewed and never stepped.
- R8: Restoring moves to disciplined with evt_code 3 on the edge that takes the SETTLE_N-th consecutive servo update whose magnitude is below BAND. An update at or above BAND resets the run.
- R9: Losing the reference while restoring discards the pending error. The cycle of loss and the cycles after it advance by exactly NOM_INC, including the first cycles of the next restore.
- R10: Whenever evt_valid is 1, evt_stamp equals time_now in that same cycle.
- R11: A load with load_time below time_now is refused (time advances normally), increments viol_count and sets viol_sticky, which stays set until reset. A load at or above time_now sets time_now to load_time without counting.
- R12: On relock, restore_time holds the number of cycles spent in restoring, and restore_late is 1 when that exceeds T_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as a reboot |
| link_up | input | 1 | Network link present |
| gm_present | input | 1 | Time reference master present |
| corr_valid | input | 1 | Servo offset update strobe |
| corr_offset | input | OFS_W | Signed reference-minus-local offset |
| load_valid | input | 1 | External time load strobe |
| load_time | input | TIME_W | Time value to load |
| time_now | output | TIME_W | Local time counter |
| state | output | 2 | Mode: 0 disciplined, 1 holdover, 2 restoring |
| holdover_flag | output | 1 | High while in holdover |
| evt_valid | output | 1 | One-cycle mode-change marker |
| evt_code | output | 2 | 1 enter holdover, 2 leave holdover, 3 relocked |
| evt_stamp | output | TIME_W | Local time at the marker |
| viol_count | output | VIOL_W | Refused backward loads, saturating |
| viol_sticky | output | 1 | Set by any refused backward load |
| restore_time | output | CNT_W | Cycles spent in the last completed restore |
| restore_late | output | 1 | Last restore exceeded T_LIMIT |

## Verification
The hardest case to reach is a reference loss while a large error is still pending in the restoring mode. From the ports, that error shows up only as a changed increment. The stimulus enters restoring, injects a large positive offset, confirms on the following edge that the increment has grown by the clamp, and then drops the link on the next edge. It then measures the increment across the holdover cycles and into the next restore to show that nothing of the old error survives. A long idle stretch inside that second restore, followed by in-band updates, drives the restore timer past its limit.

// File: rtl/hold_pkg.sv
package hold_pkg;
   typedef enum logic [1:0] {
      ST_LOCKED  = 2'd0,
      ST_HOLD    = 2'd1,
      ST_RESTORE = 2'd2
   } hstate_e;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_ENTER = 2'd1,
      EV_EXIT  = 2'd2,
      EV_LOCK  = 2'd3
   } hevt_e;
endpackage

// File: rtl/hold_slew.sv
// Turns a pending signed error into one cycle's increment: nominal plus a
// clamped delta, never below one.
module hold_slew #(
   parameter int OFS_W    = 24,
   parameter int INC_W    = 5,
   parameter int NOM_INC  = 4,
   parameter int MAX_SLEW = 6
) (
   input  logic signed [OFS_W-1:0] pend,
   output logic        [INC_W-1:0] inc,
   output logic signed [OFS_W-1:0] applied
);
   localparam int LO_D = (NOM_INC > MAX_SLEW) ? -MAX_SLEW : (1 - NOM_INC);

   if (INC_W < $clog2(NOM_INC + MAX_SLEW + 1)) begin : g_bad_incw
      $error("hold_slew: INC_W too narrow");
   end

   always_comb begin
      if (pend > OFS_W'(MAX_SLEW))
         applied = OFS_W'(MAX_SLEW);
      else if (pend < OFS_W'(LO_D))
         applied = OFS_W'(LO_D);
      else
         applied = pend;
      inc = INC_W'(NOM_INC) + INC_W'(applied);
   end
endmodule

// File: rtl/hold_guard.sv
// Monotonic guard on external time loads.
module hold_guard #(
   parameter int TIME_W = 48,
   parameter int VIOL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [TIME_W-1:0] load_time,
   input  logic [TIME_W-1:0] time_now,
   output logic              load_take,
   output logic [VIOL_W-1:0] viol_count,
   output logic              viol_sticky
);
   logic backward;

   always_comb begin
      backward  = load_valid && (load_time < time_now);
      load_take = load_valid && !backward;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_count  <= '0;
         viol_sticky <= 1'b0;
      end else if (backward) begin
         viol_sticky <= 1'b1;
         if (viol_count != {VIOL_W{1'b1}})
            viol_count <= viol_count + 1'b1;
      end
   end
endmodule

// File: rtl/hold_restore_timer.sv
// Measures cycles spent in the restoring mode.
module hold_restore_timer #(
   parameter int CNT_W   = 8,
   parameter int T_LIMIT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             in_restore,
   input  logic             done,
   output logic [CNT_W-1:0] restore_time,
   output logic             restore_late
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (T_LIMIT >= (2 ** CNT_W) - 1) begin : g_bad_limit
      $error("hold_restore_timer: T_LIMIT does not fit CNT_W");
   end

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;

   assign run_inc = (run_q == CNT_MAX) ? run_q : run_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q        <= '0;
         restore_time <= '0;
         restore_late <= 1'b0;
      end else begin
         if (start)
            run_q <= '0;
         else if (in_restore)
            run_q <= run_inc;
         if (done) begin
            restore_time <= run_inc;
            restore_late <= ({1'b0, run_inc} > (CNT_W+1)'(T_LIMIT));
         end
      end
   end
endmodule

// File: rtl/hold_restore_ctrl.sv
module hold_restore_ctrl
   import hold_pkg::*;
#(
   parameter int TIME_W   = 48,
   parameter int OFS_W    = 24,
   parameter int NOM_INC  = 4,
   parameter int MAX_SLEW = 6,
   parameter int BAND     = 4,
   parameter int SETTLE_N = 3,
   parameter int T_LIMIT  = 64,
   parameter int CNT_W    = 8,
   parameter int VIOL_W   = 8,
   parameter bit STEP_FWD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    link_up,
   input  logic                    gm_present,
   input  logic                    corr_valid,
   input  logic signed [OFS_W-1:0] corr_offset,
   input  logic                    load_valid,
   input  logic [TIME_W-1:0]       load_time,
   output logic [TIME_W-1:0]       time_now,
   output logic [1:0]              state,
   output logic                    holdover_flag,
   output logic                    evt_valid,
   output logic [1:0]              evt_code,
   output logic [TIME_W-1:0]       evt_stamp,
   output logic [VIOL_W-1:0]       viol_count,
   output logic                    viol_sticky,
   output logic [CNT_W-1:0]        restore_time,
   output logic                    restore_late
);
   localparam int INC_W = $clog2(NOM_INC + MAX_SLEW + 1) + 1;
   localparam int SET_W = $clog2(SETTLE_N + 1);

   if (NOM_INC < 1)      begin : g_bad_nom  $error("NOM_INC must be at least 1"); end
   if (MAX_SLEW < 1)     begin : g_bad_slew $error("MAX_SLEW must be at least 1"); end
   if (BAND < 1)         begin : g_bad_band $error("BAND must be at least 1"); end
   if (SETTLE_N < 1)     begin : g_bad_set  $error("SETTLE_N must be at least 1"); end
   if (TIME_W <= OFS_W)  begin : g_bad_tw   $error("TIME_W must exceed OFS_W"); end
   if (TIME_W <= INC_W)  begin : g_bad_iw   $error("TIME_W must exceed INC_W"); end

   hstate_e                 state_q, state_d;
   hevt_e                   evt_d;
   logic [TIME_W-1:0]       time_q, time_d, time_adv;
   logic signed [OFS_W-1:0] pend_q, pend_d, applied;
   logic [INC_W-1:0]        slew_inc, inc_sel;
   logic [SET_W-1:0]        settle_q, settle_d;
   logic [OFS_W-1:0]        abs_off;
   logic                    in_band, ref_ok, use_slew, step_on, fwd_cand, load_take;
   logic                    evt_valid_q;
   logic [1:0]              evt_code_q;
   logic [TIME_W-1:0]       evt_stamp_q;

   // Positive-offset handling in the disciplined mode: step or slew.
   if (STEP_FWD) begin : g_step
      assign fwd_cand = corr_valid && !corr_offset[OFS_W-1] && (corr_offset != '0);
   end else begin : g_slew_only
      assign fwd_cand = 1'b0;
   end

   hold_slew #(
      .OFS_W(OFS_W), .INC_W(INC_W), .NOM_INC(NOM_INC), .MAX_SLEW(MAX_SLEW)
   ) u_slew (
      .pend(pend_q), .inc(slew_inc), .applied(applied)
   );

   hold_guard #(.TIME_W(TIME_W), .VIOL_W(VIOL_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_time(load_time),
      .time_now(time_q), .load_take(load_take),
      .viol_count(viol_count), .viol_sticky(viol_sticky)
   );

   hold_restore_timer #(.CNT_W(CNT_W), .T_LIMIT(T_LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(state_q == ST_HOLD && state_d == ST_RESTORE),
      .in_restore(state_q == ST_RESTORE),
      .done(state_q == ST_RESTORE && state_d == ST_LOCKED),
      .restore_time(restore_time), .restore_late(restore_late)
   );

   always_comb begin
      ref_ok  = link_up && gm_present;
      abs_off = corr_offset[OFS_W-1] ? $unsigned(-corr_offset) : $unsigned(corr_offset);
      in_band = abs_off < OFS_W'(BAND);
   end

   always_comb begin
      state_d  = state_q;
      evt_d    = EV_NONE;
      pend_d   = pend_q;
      settle_d = settle_q;
      use_slew = 1'b0;
      step_on  = 1'b0;
      unique case (state_q)
         ST_HOLD: begin
            pend_d   = '0;
            settle_d = '0;
            if (ref_ok) begin
               state_d = ST_RESTORE;
               evt_d   = EV_EXIT;
            end
         end
         ST_RESTORE: begin
            if (!ref_ok) begin
               state_d  = ST_HOLD;
               evt_d    = EV_ENTER;
               pend_d   = '0;
               settle_d = '0;
            end else begin
               use_slew = 1'b1;
               pend_d   = pend_q - applied;
               if (corr_valid) begin
                  pend_d = corr_offset;
                  if (!in_band) begin
                     settle_d = '0;
                  end else if (settle_q == SET_W'(SETTLE_N - 1)) begin
                     settle_d = '0;
                     state_d  = ST_LOCKED;
                     evt_d    = EV_LOCK;
                  end else begin
                     settle_d = settle_q + 1'b1;
                  end
               end
            end
         end
         ST_LOCKED: begin
            if (!ref_ok) begin
               state_d = ST_HOLD;
               evt_d   = EV_ENTER;
               pend_d  = '0;
            end else begin
               use_slew = 1'b1;
               pend_d   = pend_q - applied;
               if (corr_valid) begin
                  if (fwd_cand) begin
                     step_on = 1'b1;
                     pend_d  = '0;
                  end else begin
                     pend_d = corr_offset;
                  end
               end
            end
         end
         default: begin
            state_d = ST_HOLD;
            pend_d  = '0;
         end
      endcase
   end

   always_comb begin
      inc_sel  = use_slew ? slew_inc : INC_W'(NOM_INC);
      time_adv = time_q + {{(TIME_W-INC_W){1'b0}}, inc_sel};
      if (step_on)
         time_adv = time_adv + {{(TIME_W-OFS_W){1'b0}}, $unsigned(corr_offset)};
      time_d = load_take ? load_time : time_adv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_HOLD;
         time_q      <= '0;
         pend_q      <= '0;
         settle_q    <= '0;
         evt_valid_q <= 1'b0;
         evt_code_q  <= EV_NONE;
         evt_stamp_q <= '0;
      end else begin
         state_q     <= state_d;
         time_q      <= time_d;
         pend_q      <= pend_d;
         settle_q    <= settle_d;
         evt_valid_q <= (evt_d != EV_NONE);
         evt_code_q  <= evt_d;
         if (evt_d != EV_NONE)
            evt_stamp_q <= time_d;
      end
   end

   assign time_now      = time_q;
   assign state         = state_q;
   assign holdover_flag = (state_q == ST_HOLD);
   assign evt_valid     = evt_valid_q;
   assign evt_code      = evt_code_q;
   assign evt_stamp     = evt_stamp_q;
endmodule

// File: rtl/hold_restore_chk.sv
module hold_restore_chk #(
   parameter int TIME_W  = 48,
   parameter int NOM_INC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_up,
   input logic              gm_present,
   input logic              load_valid,
   input logic [TIME_W-1:0] load_time,
   input logic [TIME_W-1:0] time_now,
   input logic [1:0]        state,
   input logic              evt_valid,
   input logic [1:0]        evt_code,
   input logic [TIME_W-1:0] evt_stamp,
   input logic              viol_sticky
);
   AST_TIME_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(load_valid)) |-> (time_now > $past(time_now))); // R2

   AST_HOLD_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1 && !load_valid) |=> (time_now == $past(time_now) + TIME_W'(NOM_INC))); // R6

   AST_LOSS_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd1 && !(link_up && gm_present))
      |=> (state == 2'd1 && evt_valid && evt_code == 2'd1)); // R5

   AST_RELOCK_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && $past(state) == 2'd2) |-> (evt_valid && evt_code == 2'd3)); // R8

   AST_EVT_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_stamp == time_now)); // R10

   AST_BACK_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && load_time < time_now) |=> viol_sticky); // R11

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(viol_sticky) |-> viol_sticky); // R11
endmodule

bind hold_restore_ctrl hold_restore_chk #(.TIME_W(TIME_W), .NOM_INC(NOM_INC)) u_chk (
   .clk(clk), .rst_n(rst_n), .link_up(link_up), .gm_present(gm_present),
   .load_valid(load_valid), .load_time(load_time), .time_now(time_now),
   .state(state), .evt_valid(evt_valid), .evt_code(evt_code),
   .evt_stamp(evt_stamp), .viol_sticky(viol_sticky)
);

// File: tb/hold_restore_ctrl_test.sv
`timescale 1ns/1ps
module hold_restore_ctrl_test;
   localparam int NOM = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               link_up = 1'b0, gm_present = 1'b0;
   logic               corr_valid = 1'b0;
   logic signed [23:0] corr_offset = '0;
   logic               load_valid = 1'b0;
   logic [47:0]        load_time = '0;
   logic [47:0]        time_now, evt_stamp;
   logic [1:0]         state, evt_code;
   logic               holdover_flag, evt_valid, viol_sticky, restore_late;
   logic [7:0]         viol_count, restore_time;

   int n_run = 0, n_fail = 0, mono_bad = 0;
   bit mon_on = 1'b0, done = 1'b0;
   longint t0, t1;
   logic [47:0] prev_t = '0;

   // Locked-mode vectors: offset, delta after edge 1, delta after edge 2, total over 16 edges
   localparam int NV = 9;
   localparam int V_OFF[NV] = '{5, 1, 0, -1, -2, -3, -7, -20, 40};
   localparam int V_D1[NV]  = '{9, 5, 4, 4, 4, 4, 4, 4, 44};
   localparam int V_D2[NV]  = '{4, 4, 4, 3, 2, 1, 1, 1, 4};
   localparam int V_TOT[NV] = '{69, 65, 64, 63, 62, 61, 57, 44, 104};

   hold_restore_ctrl uut (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .gm_present(gm_present),
      .corr_valid(corr_valid), .corr_offset(corr_offset),
      .load_valid(load_valid), .load_time(load_time),
      .time_now(time_now), .state(state), .holdover_flag(holdover_flag),
      .evt_valid(evt_valid), .evt_code(evt_code), .evt_stamp(evt_stamp),
      .viol_count(viol_count), .viol_sticky(viol_sticky),
      .restore_time(restore_time), .restore_late(restore_late)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input longint act, input longint exp);
      chk(act == exp, req, act, exp);
   endtask

   function automatic longint tn();
      return longint'(time_now);
   endfunction

   always @(negedge clk) begin
      if (mon_on && rst_n && !done) begin
         if (time_now < prev_t) mono_bad++;
      end
      prev_t = time_now;
   end

   initial begin
      #500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      chk_eq("R1 time", tn(), 0);
      chk_eq("R1 state", state, 1);
      chk_eq("R1 flag", holdover_flag, 1);
      chk_eq("R1 evt", evt_valid, 0);
      chk_eq("R1 viol", viol_count, 0);
      chk_eq("R1 sticky", viol_sticky, 0);
      chk_eq("R1 rtime", restore_time, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      chk_eq("R1 first advance", tn(), NOM);
      repeat (3) @(negedge clk);

      // R6 holdover ignores servo updates
      t0 = tn(); corr_valid = 1'b1; corr_offset = 24'sd50;
      @(negedge clk);
      corr_valid = 1'b0;
      chk_eq("R6 hold ignores update", tn() - t0, NOM);
      t0 = tn();
      @(negedge clk);
      chk_eq("R6 hold nominal", tn() - t0, NOM);

      // R11 backward load refused, forward load taken
      t0 = tn(); load_valid = 1'b1; load_time = 48'(t0 - 5);
      @(negedge clk);
      load_valid = 1'b0;
      chk_eq("R11 back load refused", tn() - t0, NOM);
      chk_eq("R11 viol count", viol_count, 1);
      chk_eq("R11 sticky set", viol_sticky, 1);
      t0 = tn(); load_valid = 1'b1; load_time = 48'(t0 + 1000);
      @(negedge clk);
      load_valid = 1'b0;
      chk_eq("R11 fwd load taken", tn(), t0 + 1000);
      chk_eq("R11 fwd load no count", viol_count, 1);
      repeat (4) @(negedge clk);
      chk_eq("R11 sticky holds", viol_sticky, 1);

      // R7 leave holdover, R8 relock with a run reset, R12 timing
      link_up = 1'b1; gm_present = 1'b1;
      @(negedge clk);
      chk_eq("R7 state restoring", state, 2);
      chk_eq("R7 exit marker", evt_valid ? evt_code : 0, 2);
      chk_eq("R7 flag low", holdover_flag, 0);
      chk_eq("R10 exit stamp", longint'(evt_stamp), tn());
      corr_valid = 1'b1; corr_offset = 24'sd2;
      @(negedge clk);
      corr_offset = -24'sd1;
      @(negedge clk);
      chk_eq("R8 two in band not enough", state, 2);
      corr_offset = 24'sd40;
      @(negedge clk);
      chk_eq("R8 out of band stays", state, 2);
      corr_offset = 24'sd1;
      @(negedge clk);
      corr_offset = 24'sd0;
      @(negedge clk);
      chk_eq("R8 run was reset", state, 2);
      corr_offset = -24'sd2;
      @(negedge clk);
      corr_valid = 1'b0;
      chk_eq("R8 relocked", state, 0);
      chk_eq("R8 relock marker", evt_valid ? evt_code : 0, 3);
      chk_eq("R10 relock stamp", longint'(evt_stamp), tn());
      chk_eq("R12 restore time", restore_time, 6);
      chk_eq("R12 not late", restore_late, 0);
      repeat (20) @(negedge clk);

      // R3 / R4 locked-mode vector table
      for (int i = 0; i < NV; i++) begin
         t0 = tn(); corr_valid = 1'b1; corr_offset = 24'(V_OFF[i]);
         @(negedge clk);
         corr_valid = 1'b0;
         chk_eq($sformatf("R3 vec%0d first edge", i), tn() - t0, V_D1[i]);
         t1 = tn();
         @(negedge clk);
         chk_eq($sformatf("R4 vec%0d second edge", i), tn() - t1, V_D2[i]);
         repeat (14) @(negedge clk);
         chk_eq($sformatf("R4 vec%0d total", i), tn() - t0, V_TOT[i]);
      end
      chk_eq("R3 still locked", state, 0);

      // R5 loss while locked
      gm_present = 1'b0;
      @(negedge clk);
      chk_eq("R5 state hold", state, 1);
      chk_eq("R5 flag", holdover_flag, 1);
      chk_eq("R5 enter marker", evt_valid ? evt_code : 0, 1);
      chk_eq("R10 enter stamp", longint'(evt_stamp), tn());
      @(negedge clk);
      chk_eq("R5 marker one cycle", evt_valid, 0);

      // R7 slewing in restoring, R9 loss drops pending error
      gm_present = 1'b1;
      @(negedge clk);
      chk_eq("R7 restoring again", state, 2);
      t0 = tn(); corr_valid = 1'b1; corr_offset = 24'sd30;
      @(negedge clk);
      corr_valid = 1'b0;
      chk_eq("R7 no step in restore", tn() - t0, NOM);
      t1 = tn();
      @(negedge clk);
      chk_eq("R7 slew clamp up", tn() - t1, NOM + 6);
      t1 = tn(); link_up = 1'b0;
      @(negedge clk);
      chk_eq("R9 loss cycle nominal", tn() - t1, NOM);
      chk_eq("R9 back in hold", state, 1);
      @(negedge clk);
      link_up = 1'b1;
      @(negedge clk);
      chk_eq("R9 restoring", state, 2);
      t1 = tn();
      @(negedge clk);
      chk_eq("R9 pending dropped", tn() - t1, NOM);

      // R12 late restore: 72 cycles in restoring
      repeat (68) @(negedge clk);
      corr_valid = 1'b1; corr_offset = 24'sd0;
      repeat (3) @(negedge clk);
      corr_valid = 1'b0;
      chk_eq("R12 relock after wait", state, 0);
      chk_eq("R12 late time", restore_time, 72);
      chk_eq("R12 late flag", restore_late, 1);

      chk_eq("R2 never backward", mono_bad, 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule